// File: doc/BRIEF.md
# Processor Sleep State Controller

This block is the state machine that decides how deeply a processor core is asleep and drives the power controls that follow from that level. These controls are the gate enables for the core clock, the interrupt controller clock and the bus interface clock, the clock generator (PLL) enable, a two-bit supply voltage level, a cache power-off flag, and one-cycle strobes that save and restore the core context in a separately powered SRAM. A 4-bit state code reports the current level.

Levels are reached as a staircase. A halt request or a stop-clock pin takes the core out of the running state. The sleep pin, asserted while stop-clock is held, leads to deep sleep. Further requests then step down to deeper sleep, to deeper sleep with the cache off, and to power-down. In the two shallow levels an interrupt opens a snoop state that restores the clocks for servicing and then returns to the level it left. An enhanced-mode configuration bit selects voltage-reduced variants of the shallow levels. Waking from deep sleep or any level below it climbs back one level at a time, and each level has its own dwell time as a parameter.

Top module: `sleep_level_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block enters running (state_code 0) with every clock enable and pll_en at 1, volt_lvl 00 (nominal), cache_off 0, and both strobes 0.
- R2: In running with stop_clk low, halt_req moves to halt (code 1, volt_lvl 00), or to enhanced halt (code 2, volt_lvl 01) when enh_cfg is 1. Both gate the core clock and keep the interrupt controller clock, the bus clock and the PLL on. Both return to running when halt_req drops.
- R3: An irq in halt enters halt snoop (code 3). An irq in enhanced halt enters enhanced halt snoop (code 4). Both have all clocks on. Code 4 keeps volt_lvl 01. isr_done returns to the level the snoop came from.
- R4: stop_clk in running enters stop-grant (code 5), or enhanced stop-grant (code 6, volt_lvl 01) when enh_cfg is 1. stop_clk wins over halt_req. Core clock off, interrupt controller and bus clocks and PLL on. Dropping stop_clk returns to running.
- R5: An irq in stop-grant enters code 7, and in enhanced stop-grant enters code 8, with all clocks on. isr_done returns to the originating stop-grant level.
- R6: sleep_pin in a stop-grant level with stop_clk held enters deep sleep (code 9). All three clock enables and pll_en are 0. irq has no effect in deep sleep or below. sleep_pin without stop_clk in running has no effect.
- R7: deeper_req in deep sleep, with sleep_pin high, enters deeper sleep (code 10, volt_lvl 10). l2_off_req in deeper sleep enters code 11, which adds cache_off 1. deeper_req in stop-grant has no effect.
- R8: pdown_req in code 10 or 11 enters context save (code 12) for exactly one cycle with ctx_save 1. The block then enters power-down (code 13, volt_lvl 11, cache_off 1).
- R9: With sleep_pin low, each level from code 9 to 13 holds for its dwell parameter plus one cycles and then steps up: 13 to 14, 11 to 10, 10 to 9, and 9 to stop-grant (code 6 if enh_cfg is 1, else code 5). If sleep_pin rises again, the climb pauses and the dwell count restarts.
- R10: Leaving power-down always passes through context restore (code 14). This state lasts exactly one cycle with ctx_restore 1 and volt_lvl 10, and then goes to code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Halt request, held while halted |
| stop_clk | input | 1 | Stop-clock pin |
| sleep_pin | input | 1 | Sleep pin, high requests deep sleep or below |
| deeper_req | input | 1 | Step from deep to deeper sleep |
| l2_off_req | input | 1 | Power off the cache in deeper sleep |
| pdown_req | input | 1 | Step from deeper sleep to power-down |
| irq | input | 1 | Interrupt line |
| isr_done | input | 1 | Interrupt servicing finished |
| enh_cfg | input | 1 | Select voltage-reduced shallow variants |
| core_clk_en | output | 1 | Core clock gate enable |
| intc_clk_en | output | 1 | Interrupt controller clock gate enable |
| bus_clk_en | output | 1 | Bus interface clock gate enable |
| pll_en | output | 1 | Clock generator enable |
| volt_lvl | output | 2 | 00 nominal, 01 reduced, 10 lower, 11 off |
| cache_off | output | 1 | Cache power removed |
| ctx_save | output | 1 | One-cycle context save strobe |
| ctx_restore | output | 1 | One-cycle context restore strobe |
| state_code | output | 4 | Current level code |

## Verification
The hardest situation to reach is the full climb out of power-down, where the one-cycle restore state and three separate dwell windows must line up. The stimulus gets there by walking the whole staircase from running, asserting stop_clk, then sleep_pin, then each step request for a single cycle. It then drops sleep_pin and counts cycles against each dwell parameter. A separate scenario raises sleep_pin again in the middle of the deep-sleep dwell to show that the count restarts.

// File: rtl/slp_pkg.sv
// Shared types for the sleep level controller.
// Assumes state codes are the externally visible level codes.
package slp_pkg;

    typedef enum logic [3:0] {
        ST_RUN      = 4'd0,
        ST_HALT     = 4'd1,
        ST_HALT_E   = 4'd2,
        ST_SNP_H    = 4'd3,
        ST_SNP_HE   = 4'd4,
        ST_SG       = 4'd5,
        ST_SG_E     = 4'd6,
        ST_SNP_SG   = 4'd7,
        ST_SNP_SGE  = 4'd8,
        ST_DEEP     = 4'd9,
        ST_DEEPER   = 4'd10,
        ST_DEEPER_C = 4'd11,
        ST_SAVE     = 4'd12,
        ST_PDOWN    = 4'd13,
        ST_RESTORE  = 4'd14
    } slp_state_e;

    localparam logic [1:0] V_NOM   = 2'b00;
    localparam logic [1:0] V_RED   = 2'b01;
    localparam logic [1:0] V_LOWER = 2'b10;
    localparam logic [1:0] V_OFF   = 2'b11;

    // True for levels that climb one step when the sleep pin is low.
    function automatic logic is_climb_level(slp_state_e s);
        return (s == ST_DEEP) || (s == ST_DEEPER) ||
               (s == ST_DEEPER_C) || (s == ST_PDOWN);
    endfunction

endpackage

// File: rtl/slp_wake_timer.sv
// Dwell counter for the wake climb.
// Reloads with the dwell of the level about to be held and counts down to zero.
// Assumes limit fits in CNT_W bits.
module slp_wake_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Reload on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (reload)
            cnt <= limit;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Dwell expiry flag.
    always_comb done = (cnt == '0);

endmodule

// File: rtl/slp_fsm.sv
// Sleep level state machine.
// Enforces the entry staircase, the snoop returns and the one-step wake climb.
// Assumes all inputs are synchronous to clk.
module slp_fsm
    import slp_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter int WAKE_DEEP    = 3,
    parameter int WAKE_DEEPER  = 5,
    parameter int WAKE_CACHE   = 7,
    parameter int WAKE_PDOWN   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             stop_clk,
    input  logic             sleep_pin,
    input  logic             deeper_req,
    input  logic             l2_off_req,
    input  logic             pdown_req,
    input  logic             irq,
    input  logic             isr_done,
    input  logic             enh_cfg,
    input  logic             dwell_done,
    output logic             dwell_reload,
    output logic [CNT_W-1:0] dwell_limit,
    output slp_state_e       state
);
    slp_state_e state_nxt;
    logic       climb;

    // Climb is active in the deep family while the sleep pin is low.
    always_comb climb = is_climb_level(state) && !sleep_pin;

    // Next-level selection.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (stop_clk)      state_nxt = enh_cfg ? ST_SG_E : ST_SG;
                else if (halt_req) state_nxt = enh_cfg ? ST_HALT_E : ST_HALT;
            end
            ST_HALT: begin
                if (irq)           state_nxt = ST_SNP_H;
                else if (!halt_req) state_nxt = ST_RUN;
            end
            ST_HALT_E: begin
                if (irq)           state_nxt = ST_SNP_HE;
                else if (!halt_req) state_nxt = ST_RUN;
            end
            ST_SNP_H:   if (isr_done) state_nxt = ST_HALT;
            ST_SNP_HE:  if (isr_done) state_nxt = ST_HALT_E;
            ST_SG, ST_SG_E: begin
                if (!stop_clk)     state_nxt = ST_RUN;
                else if (sleep_pin) state_nxt = ST_DEEP;
                else if (irq)      state_nxt = (state == ST_SG) ? ST_SNP_SG : ST_SNP_SGE;
            end
            ST_SNP_SG:  if (isr_done) state_nxt = ST_SG;
            ST_SNP_SGE: if (isr_done) state_nxt = ST_SG_E;
            ST_DEEP: begin
                if (climb && dwell_done)      state_nxt = enh_cfg ? ST_SG_E : ST_SG;
                else if (sleep_pin && deeper_req) state_nxt = ST_DEEPER;
            end
            ST_DEEPER: begin
                if (climb && dwell_done)      state_nxt = ST_DEEP;
                else if (sleep_pin && pdown_req)  state_nxt = ST_SAVE;
                else if (sleep_pin && l2_off_req) state_nxt = ST_DEEPER_C;
            end
            ST_DEEPER_C: begin
                if (climb && dwell_done)      state_nxt = ST_DEEPER;
                else if (sleep_pin && pdown_req)  state_nxt = ST_SAVE;
            end
            ST_SAVE:    state_nxt = ST_PDOWN;
            ST_PDOWN:   if (climb && dwell_done) state_nxt = ST_RESTORE;
            ST_RESTORE: state_nxt = ST_DEEPER;
            default:    state_nxt = ST_RUN;
        endcase
    end

    // Dwell of the level that will be held next.
    always_comb begin
        unique case (state_nxt)
            ST_DEEP:     dwell_limit = CNT_W'(WAKE_DEEP);
            ST_DEEPER:   dwell_limit = CNT_W'(WAKE_DEEPER);
            ST_DEEPER_C: dwell_limit = CNT_W'(WAKE_CACHE);
            ST_PDOWN:    dwell_limit = CNT_W'(WAKE_PDOWN);
            default:     dwell_limit = '0;
        endcase
    end

    // Restart the dwell whenever the climb stalls or a level is left.
    always_comb dwell_reload = !climb || (state_nxt != state);

    // Level register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    // R6
    deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP && $past(state) != ST_DEEP) |->
        ($past(state) == ST_SG || $past(state) == ST_SG_E || $past(state) == ST_DEEPER));

    // R8
    save_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAVE) |->
        ($past(state) == ST_DEEPER || $past(state) == ST_DEEPER_C));

    // R10
    pdown_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_PDOWN && state != ST_PDOWN) |-> (state == ST_RESTORE));

    // R9
    climb_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_DEEP && (state == ST_SG || state == ST_SG_E)) |-> !$past(sleep_pin));

    // R6
    deep_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP && sleep_pin && !deeper_req) |=> (state == ST_DEEP));

endmodule

// File: rtl/slp_out_decode.sv
// Decodes the current level into clock gates, voltage, cache and strobes.
// Assumes a pure function of the level so every output changes with the state register.
module slp_out_decode
    import slp_pkg::*;
(
    input  slp_state_e  state,
    output logic        core_clk_en,
    output logic        intc_clk_en,
    output logic        bus_clk_en,
    output logic        pll_en,
    output logic [1:0]  volt_lvl,
    output logic        cache_off,
    output logic        ctx_save,
    output logic        ctx_restore,
    output logic [3:0]  state_code
);
    // Per-level output table.
    always_comb begin
        core_clk_en = 1'b1;
        intc_clk_en = 1'b1;
        bus_clk_en  = 1'b1;
        pll_en      = 1'b1;
        volt_lvl    = V_NOM;
        cache_off   = 1'b0;
        ctx_save    = 1'b0;
        ctx_restore = 1'b0;
        unique case (state)
            ST_RUN, ST_SNP_H, ST_SNP_SG: ;
            ST_SNP_HE, ST_SNP_SGE: volt_lvl = V_RED;
            ST_HALT, ST_SG: core_clk_en = 1'b0;
            ST_HALT_E, ST_SG_E: begin
                core_clk_en = 1'b0;
                volt_lvl    = V_RED;
            end
            default: begin
                core_clk_en = 1'b0;
                intc_clk_en = 1'b0;
                bus_clk_en  = 1'b0;
                pll_en      = 1'b0;
                unique case (state)
                    ST_DEEPER:   volt_lvl = V_LOWER;
                    ST_DEEPER_C: begin volt_lvl = V_LOWER; cache_off = 1'b1; end
                    ST_SAVE:     begin volt_lvl = V_LOWER; cache_off = 1'b1; ctx_save = 1'b1; end
                    ST_PDOWN:    begin volt_lvl = V_OFF;   cache_off = 1'b1; end
                    ST_RESTORE:  begin volt_lvl = V_LOWER; cache_off = 1'b1; ctx_restore = 1'b1; end
                    default:     volt_lvl = V_NOM;
                endcase
            end
        endcase
    end

    // Visible level code.
    always_comb state_code = state;

endmodule

// File: rtl/sleep_level_ctrl.sv
// Top of the processor sleep level controller.
// Ties the level machine, the wake dwell counter and the output decode together.
// Assumes synchronous inputs and a synchronous active-low reset.
module sleep_level_ctrl
    import slp_pkg::*;
#(
    parameter int WAKE_DEEP   = 3,
    parameter int WAKE_DEEPER = 5,
    parameter int WAKE_CACHE  = 7,
    parameter int WAKE_PDOWN  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       stop_clk,
    input  logic       sleep_pin,
    input  logic       deeper_req,
    input  logic       l2_off_req,
    input  logic       pdown_req,
    input  logic       irq,
    input  logic       isr_done,
    input  logic       enh_cfg,
    output logic       core_clk_en,
    output logic       intc_clk_en,
    output logic       bus_clk_en,
    output logic       pll_en,
    output logic [1:0] volt_lvl,
    output logic       cache_off,
    output logic       ctx_save,
    output logic       ctx_restore,
    output logic [3:0] state_code
);
    localparam int MAX_A  = (WAKE_DEEP  > WAKE_DEEPER) ? WAKE_DEEP  : WAKE_DEEPER;
    localparam int MAX_B  = (WAKE_CACHE > WAKE_PDOWN)  ? WAKE_CACHE : WAKE_PDOWN;
    localparam int MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = (MAX_W < 1) ? 1 : $clog2(MAX_W + 1);

    slp_state_e       state;
    logic             dwell_done;
    logic             dwell_reload;
    logic [CNT_W-1:0] dwell_limit;

    slp_fsm #(
        .CNT_W       (CNT_W),
        .WAKE_DEEP   (WAKE_DEEP),
        .WAKE_DEEPER (WAKE_DEEPER),
        .WAKE_CACHE  (WAKE_CACHE),
        .WAKE_PDOWN  (WAKE_PDOWN)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_req     (halt_req),
        .stop_clk     (stop_clk),
        .sleep_pin    (sleep_pin),
        .deeper_req   (deeper_req),
        .l2_off_req   (l2_off_req),
        .pdown_req    (pdown_req),
        .irq          (irq),
        .isr_done     (isr_done),
        .enh_cfg      (enh_cfg),
        .dwell_done   (dwell_done),
        .dwell_reload (dwell_reload),
        .dwell_limit  (dwell_limit),
        .state        (state)
    );

    slp_wake_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (dwell_reload),
        .limit  (dwell_limit),
        .done   (dwell_done)
    );

    slp_out_decode u_dec (
        .state       (state),
        .core_clk_en (core_clk_en),
        .intc_clk_en (intc_clk_en),
        .bus_clk_en  (bus_clk_en),
        .pll_en      (pll_en),
        .volt_lvl    (volt_lvl),
        .cache_off   (cache_off),
        .ctx_save    (ctx_save),
        .ctx_restore (ctx_restore),
        .state_code  (state_code)
    );

    // R8
    save_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_save |=> (!ctx_save && state_code == 4'd13));

    // R6
    deep_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!intc_clk_en) |-> (!pll_en && !bus_clk_en && !core_clk_en));

    // R1
    reset_run_chk: assert property (@(posedge clk)
        !rst_n |=> (state_code == 4'd0 && core_clk_en && pll_en && volt_lvl == 2'b00));

endmodule

// File: tb/test_sleep_level_ctrl.sv
module test_sleep_level_ctrl;
    localparam int WD = 3, WR = 5, WC = 7, WP = 10;

    logic clk = 0, rst_n = 0;
    logic halt_req = 0, stop_clk = 0, sleep_pin = 0, deeper_req = 0;
    logic l2_off_req = 0, pdown_req = 0, irq = 0, isr_done = 0, enh_cfg = 0;
    logic core_clk_en, intc_clk_en, bus_clk_en, pll_en, cache_off, ctx_save, ctx_restore;
    logic [1:0] volt_lvl;
    logic [3:0] state_code;
    int checks = 0, errors = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    sleep_level_ctrl #(.WAKE_DEEP(WD), .WAKE_DEEPER(WR), .WAKE_CACHE(WC), .WAKE_PDOWN(WP))
    i_sleep_level_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_clk(stop_clk),
        .sleep_pin(sleep_pin), .deeper_req(deeper_req), .l2_off_req(l2_off_req),
        .pdown_req(pdown_req), .irq(irq), .isr_done(isr_done), .enh_cfg(enh_cfg),
        .core_clk_en(core_clk_en), .intc_clk_en(intc_clk_en), .bus_clk_en(bus_clk_en),
        .pll_en(pll_en), .volt_lvl(volt_lvl), .cache_off(cache_off),
        .ctx_save(ctx_save), .ctx_restore(ctx_restore), .state_code(state_code));

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // clocks packed as core,intc,bus,pll
    function automatic int clks();
        return {core_clk_en, intc_clk_en, bus_clk_en, pll_en};
    endfunction

    task automatic t_reset();
        rst_n = 0; tick(3);
        chk("R1", "code", state_code, 0);
        chk("R1", "clocks", clks(), 4'b1111);
        chk("R1", "volt", volt_lvl, 0);
        chk("R1", "cache/strobes", {cache_off, ctx_save, ctx_restore}, 0);
        rst_n = 1; tick(1);
    endtask

    task automatic t_halt();
        halt_req = 1; tick(1);
        chk("R2", "halt code", state_code, 1);
        chk("R2", "halt clocks", clks(), 4'b0111);
        chk("R2", "halt volt", volt_lvl, 0);
        irq = 1; tick(1); irq = 0;
        chk("R3", "snoop code", state_code, 3);
        chk("R3", "snoop clocks", clks(), 4'b1111);
        tick(1);
        chk("R3", "snoop holds", state_code, 3);
        isr_done = 1; tick(1); isr_done = 0;
        chk("R3", "return halt", state_code, 1);
        halt_req = 0; tick(1);
        chk("R2", "halt exit", state_code, 0);
        enh_cfg = 1; halt_req = 1; tick(1);
        chk("R2", "enh halt code", state_code, 2);
        chk("R2", "enh halt volt", volt_lvl, 1);
        irq = 1; tick(1); irq = 0;
        chk("R3", "enh snoop code", state_code, 4);
        chk("R3", "enh snoop volt", volt_lvl, 1);
        chk("R3", "enh snoop clocks", clks(), 4'b1111);
        isr_done = 1; tick(1); isr_done = 0;
        chk("R3", "return enh halt", state_code, 2);
        halt_req = 0; enh_cfg = 0; tick(1);
        chk("R2", "enh halt exit", state_code, 0);
    endtask

    task automatic t_stop_grant();
        stop_clk = 1; halt_req = 1; tick(1); halt_req = 0;
        chk("R4", "priority sg", state_code, 5);
        chk("R4", "sg clocks", clks(), 4'b0111);
        irq = 1; tick(1); irq = 0;
        chk("R5", "sg snoop", state_code, 7);
        chk("R5", "sg snoop clocks", clks(), 4'b1111);
        isr_done = 1; tick(1); isr_done = 0;
        chk("R5", "return sg", state_code, 5);
        deeper_req = 1; tick(1); deeper_req = 0;
        chk("R7", "deeper ignored in sg", state_code, 5);
        stop_clk = 0; tick(1);
        chk("R4", "sg exit", state_code, 0);
        enh_cfg = 1; stop_clk = 1; tick(1);
        chk("R4", "enh sg", state_code, 6);
        chk("R4", "enh sg volt", volt_lvl, 1);
        irq = 1; tick(1); irq = 0;
        chk("R5", "enh sg snoop", state_code, 8);
        isr_done = 1; tick(1); isr_done = 0;
        chk("R5", "return enh sg", state_code, 6);
        stop_clk = 0; enh_cfg = 0; tick(1);
        chk("R4", "enh sg exit", state_code, 0);
    endtask

    task automatic t_deep_ignore();
        sleep_pin = 1; tick(2);
        chk("R6", "sleep w/o stop_clk", state_code, 0);
        stop_clk = 1; tick(1);
        chk("R6", "sg with sleep held", state_code, 5);
        tick(1);
        chk("R6", "deep code", state_code, 9);
        chk("R6", "deep clocks", clks(), 4'b0000);
        irq = 1; tick(2); irq = 0;
        chk("R6", "irq ignored", state_code, 9);
    endtask

    task automatic t_wake_pause();
        sleep_pin = 0; tick(2);
        chk("R9", "deep mid dwell", state_code, 9);
        sleep_pin = 1; tick(3);
        chk("R9", "paused", state_code, 9);
        sleep_pin = 0; tick(WD);
        chk("R9", "dwell restarted", state_code, 9);
        tick(1);
        chk("R9", "deep to sg", state_code, 5);
        stop_clk = 0; tick(1);
        chk("R9", "sg to run", state_code, 0);
    endtask

    task automatic t_cache_climb();
        stop_clk = 1; tick(1); sleep_pin = 1; tick(1);
        deeper_req = 1; tick(1); deeper_req = 0;
        chk("R7", "deeper code", state_code, 10);
        chk("R7", "deeper volt", volt_lvl, 2);
        l2_off_req = 1; tick(1); l2_off_req = 0;
        chk("R7", "cache off code", state_code, 11);
        chk("R7", "cache off flag", cache_off, 1);
        enh_cfg = 1; sleep_pin = 0; tick(WC);
        chk("R9", "cache dwell", state_code, 11);
        tick(1);
        chk("R9", "to deeper", state_code, 10);
        chk("R9", "cache back on", cache_off, 0);
        tick(WR);
        chk("R9", "deeper dwell", state_code, 10);
        tick(1);
        chk("R9", "to deep", state_code, 9);
        tick(WD + 1);
        chk("R9", "to enh sg", state_code, 6);
        stop_clk = 0; enh_cfg = 0; tick(1);
        chk("R9", "run", state_code, 0);
    endtask

    task automatic t_power_down();
        stop_clk = 1; tick(1); sleep_pin = 1; tick(1);
        deeper_req = 1; tick(1); deeper_req = 0;
        pdown_req = 1; tick(1); pdown_req = 0;
        chk("R8", "save code", state_code, 12);
        chk("R8", "save strobe", ctx_save, 1);
        tick(1);
        chk("R8", "pdown code", state_code, 13);
        chk("R8", "strobe one cycle", ctx_save, 0);
        chk("R8", "pdown volt/cache", {volt_lvl, cache_off}, 3'b111);
        sleep_pin = 0; tick(WP);
        chk("R9", "pdown dwell", state_code, 13);
        tick(1);
        chk("R10", "restore code", state_code, 14);
        chk("R10", "restore strobe/volt", {ctx_restore, volt_lvl}, 3'b110);
        tick(1);
        chk("R10", "restore to deeper", state_code, 10);
        chk("R10", "restore one cycle", ctx_restore, 0);
        tick(WR + 1);
        chk("R9", "to deep", state_code, 9);
        tick(WD + 1);
        chk("R9", "to sg", state_code, 5);
        stop_clk = 0; tick(1);
        chk("R9", "back to run", state_code, 0);
        chk("R1", "run clocks", clks(), 4'b1111);
    endtask

    initial begin
        t_reset();
        t_halt();
        t_stop_grant();
        t_deep_ignore();
        t_wake_pause();
        t_cache_climb();
        t_power_down();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule